// File: doc/BRIEF.md
# Three-Dimensional DMA Address Generator

This block walks one DMA transfer laid out in three nested dimensions and produces the addresses for it. The innermost unit is the array, a run of contiguous bytes. A frame is a group of arrays, and a block is a group of frames. The generator emits one beat per array on a valid/ready stream. Each beat carries the source start address, the destination start address and the array length in bytes. The bus engine downstream moves the bytes.

A parameter set is written either into the active slot or into one of a few link slots. It holds:
- the base addresses and the three counts;
- a signed array stride and a signed frame stride for each side;
- a fixed-address (FIFO) flag for each side;
- a trigger granularity;
- a completion code;
- a link pointer.

Each trigger releases one array, one frame or the whole block, depending on the granularity. When the last array of the block is accepted, the block pulses a completion strobe. It then either copies the linked slot into the active set or clears the active set to a null set.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `done` and `miss` are low, and the active set is null, so a trigger produces no beat.
- R2: With granularity 0 (array), each trigger produces exactly one beat. `beat_len` equals the byte count, and `beat_len` is the same on every beat.
- R3: With granularity 1 (frame), each trigger produces exactly `bcnt` beats, one per array of the current frame.
- R4: With granularity 2 or 3 (block), one trigger produces all `bcnt*ccnt` beats of the block.
- R5: Within a frame, an incrementing side advances by its signed array stride from one array to the next. The first array of the next frame sits at the previous frame's first address plus that side's signed frame stride.
- R6: Source and destination use their own strides, so the two sides can step by different amounts, including negative ones.
- R7: A side whose FIFO flag is 1 presents the same address on every beat of the set, whatever the strides.
- R8: While `beat_valid` is high and `beat_ready` is low, the beat's addresses and length stay unchanged.
- R9: `done` is a one-cycle pulse. It appears in the cycle after the final beat of the block is accepted, with `done_code` equal to the completion code of the finished set. `beat_valid` is low during that pulse.
- R10: If the finished set's link pointer is not all ones, the link slot selected by its low bits becomes the active set. The next trigger walks that set from its base addresses, and a slot that links to itself repeats.
- R11: If the link pointer is all ones, the active set becomes null (all counts zero). Later triggers produce no beat, no `done` and no `miss`.
- R12: A trigger that arrives while `beat_valid` is high raises `miss` for one cycle. It is dropped: no extra beats follow the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a parameter set |
| wr_link | input | 1 | 1: write link slot `wr_slot`; 0: write the active set |
| wr_slot | input | SW | Link slot index |
| wr_src | input | AW | Source base address |
| wr_dst | input | AW | Destination base address |
| wr_acnt | input | CW | Bytes per array |
| wr_bcnt | input | CW | Arrays per frame |
| wr_ccnt | input | CW | Frames per block |
| wr_src_bidx | input | CW | Signed source array stride |
| wr_dst_bidx | input | CW | Signed destination array stride |
| wr_src_cidx | input | CW | Signed source frame stride |
| wr_dst_cidx | input | CW | Signed destination frame stride |
| wr_src_fifo | input | 1 | Source address fixed |
| wr_dst_fifo | input | 1 | Destination address fixed |
| wr_sync | input | 2 | Trigger granularity: 0 array, 1 frame, 2/3 block |
| wr_tcc | input | TW | Completion code |
| wr_link_addr | input | CW | Link pointer; all ones means no link |
| trig | input | 1 | Transfer trigger |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Beat accepted when high with valid |
| beat_src | output | AW | Source address of the array |
| beat_dst | output | AW | Destination address of the array |
| beat_len | output | CW | Array length in bytes |
| done | output | 1 | Block completion pulse |
| done_code | output | TW | Completion code for `done` |
| miss | output | 1 | Trigger arrived while busy |

## Verification
The hardest case to reach is a trigger that lands while a burst is still in flight. At full throughput a frame burst lasts only a few cycles. The bench therefore holds `beat_ready` low, so the first beat stays pending, and issues the second trigger inside that stall. It then releases the stream and counts the beats to confirm the dropped trigger added none. Reaching link reload needs a whole block to finish, so the bench preloads a self-linking slot, walks a frame-mode set to its end, and triggers the reloaded set twice.

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int TW    = 4,
  parameter int NSETS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_link,
  input  logic [$clog2(NSETS)-1:0] wr_slot,
  input  logic [AW-1:0]     wr_src,
  input  logic [AW-1:0]     wr_dst,
  input  logic [CW-1:0]     wr_acnt,
  input  logic [CW-1:0]     wr_bcnt,
  input  logic [CW-1:0]     wr_ccnt,
  input  logic [CW-1:0]     wr_src_bidx,
  input  logic [CW-1:0]     wr_dst_bidx,
  input  logic [CW-1:0]     wr_src_cidx,
  input  logic [CW-1:0]     wr_dst_cidx,
  input  logic              wr_src_fifo,
  input  logic              wr_dst_fifo,
  input  logic [1:0]        wr_sync,
  input  logic [TW-1:0]     wr_tcc,
  input  logic [CW-1:0]     wr_link_addr,
  input  logic              trig,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [AW-1:0]     beat_src,
  output logic [AW-1:0]     beat_dst,
  output logic [CW-1:0]     beat_len,
  output logic              done,
  output logic [TW-1:0]     done_code,
  output logic              miss
);
  localparam int SW = $clog2(NSETS);
  localparam int RW = 7*CW + 4 + TW + CW;
  localparam int PW = 2*AW + RW;
  localparam logic [CW-1:0] NO_LINK = '1;
  localparam logic [1:0] SY_ARR = 2'd0, SY_FRM = 2'd1;

  logic [PW-1:0] slots [NSETS];
  logic [RW-1:0] cfg;
  logic [AW-1:0] cur_src, cur_dst, frm_src, frm_dst;
  logic [CW-1:0] brem, crem;
  logic          busy;

  logic [CW-1:0] c_acnt, c_bcnt, c_ccnt, c_sb, c_db, c_sc, c_dc, c_link;
  logic          c_sf, c_df;
  logic [1:0]    c_sync;
  logic [TW-1:0] c_tcc;
  assign {c_acnt, c_bcnt, c_ccnt, c_sb, c_db, c_sc, c_dc, c_sf, c_df, c_sync, c_tcc, c_link} = cfg;

  logic [PW-1:0] wr_pack, n_pack;
  assign wr_pack = {wr_src, wr_dst, wr_acnt, wr_bcnt, wr_ccnt, wr_src_bidx, wr_dst_bidx,
                    wr_src_cidx, wr_dst_cidx, wr_src_fifo, wr_dst_fifo, wr_sync, wr_tcc, wr_link_addr};

  logic wr_act;
  assign wr_act = wr_en && !wr_link;
  assign n_pack = wr_act ? wr_pack : slots[c_link[SW-1:0]];

  function automatic logic [AW-1:0] sx(input logic [CW-1:0] v);
    return {{(AW-CW){v[CW-1]}}, v};
  endfunction

  logic fire, last_arr, last_frm, nul;
  logic [AW-1:0] a_src, a_dst, f_src, f_dst;
  assign fire     = busy && beat_ready;
  assign last_arr = brem <= 1;
  assign last_frm = crem <= 1;
  assign nul      = (c_acnt == 0) || (c_bcnt == 0) || (c_ccnt == 0);
  assign a_src    = c_sf ? cur_src : cur_src + sx(c_sb);
  assign a_dst    = c_df ? cur_dst : cur_dst + sx(c_db);
  assign f_src    = c_sf ? frm_src : frm_src + sx(c_sc);
  assign f_dst    = c_df ? frm_dst : frm_dst + sx(c_dc);

  always_ff @(posedge clk)
    if (wr_en && wr_link) slots[wr_slot] <= wr_pack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= {{(RW-CW){1'b0}}, NO_LINK};
      cur_src   <= '0; cur_dst <= '0; frm_src <= '0; frm_dst <= '0;
      brem      <= '0; crem    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      done_code <= '0;
      miss      <= 1'b0;
    end else begin
      done <= 1'b0;
      miss <= trig && busy;
      if (wr_act) begin
        cfg     <= n_pack[RW-1:0];
        cur_src <= n_pack[PW-1 -: AW];    frm_src <= n_pack[PW-1 -: AW];
        cur_dst <= n_pack[PW-AW-1 -: AW]; frm_dst <= n_pack[PW-AW-1 -: AW];
        brem    <= n_pack[RW-CW-1 -: CW];
        crem    <= n_pack[RW-2*CW-1 -: CW];
        busy    <= 1'b0;
      end else if (fire) begin
        if (last_arr && last_frm) begin
          done      <= 1'b1;
          done_code <= c_tcc;
          busy      <= 1'b0;
          if (c_link != NO_LINK) begin
            cfg     <= n_pack[RW-1:0];
            cur_src <= n_pack[PW-1 -: AW];    frm_src <= n_pack[PW-1 -: AW];
            cur_dst <= n_pack[PW-AW-1 -: AW]; frm_dst <= n_pack[PW-AW-1 -: AW];
            brem    <= n_pack[RW-CW-1 -: CW];
            crem    <= n_pack[RW-2*CW-1 -: CW];
          end else begin
            cfg  <= {{(RW-CW){1'b0}}, NO_LINK};
            brem <= '0;
            crem <= '0;
          end
        end else if (last_arr) begin
          cur_src <= f_src; frm_src <= f_src;
          cur_dst <= f_dst; frm_dst <= f_dst;
          brem    <= c_bcnt;
          crem    <= crem - 1'b1;
          if (c_sync == SY_ARR || c_sync == SY_FRM) busy <= 1'b0;
        end else begin
          cur_src <= a_src;
          cur_dst <= a_dst;
          brem    <= brem - 1'b1;
          if (c_sync == SY_ARR) busy <= 1'b0;
        end
      end else if (trig && !busy && !nul) begin
        busy <= 1'b1;
      end
    end
  end

  assign beat_valid = busy;
  assign beat_src   = cur_src;
  assign beat_dst   = cur_dst;
  assign beat_len   = c_acnt;
endmodule

// File: rtl/dma3d_addr_gen_chk.sv
module dma3d_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_src,
  input logic [AW-1:0] beat_dst,
  input logic [CW-1:0] beat_len,
  input logic          done,
  input logic          miss
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_src) && $stable(beat_dst) && $stable(beat_len)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_valid && beat_ready)); // R9
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid); // R9
  AST_MISS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $past(trig && beat_valid)); // R12
endmodule

bind dma3d_addr_gen dma3d_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_src(beat_src), .beat_dst(beat_dst), .beat_len(beat_len), .done(done), .miss(miss)
);

// File: tb/dma3d_addr_gen_test.sv
module dma3d_addr_gen_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_link = 0;
  logic [1:0]  wr_slot = 0;
  logic [31:0] wr_src = 0, wr_dst = 0;
  logic [15:0] wr_acnt = 0, wr_bcnt = 0, wr_ccnt = 0;
  logic [15:0] wr_src_bidx = 0, wr_dst_bidx = 0, wr_src_cidx = 0, wr_dst_cidx = 0;
  logic        wr_src_fifo = 0, wr_dst_fifo = 0;
  logic [1:0]  wr_sync = 0;
  logic [3:0]  wr_tcc = 0;
  logic [15:0] wr_link_addr = 0;
  logic        trig = 0, beat_ready = 1;
  logic        beat_valid, done, miss;
  logic [31:0] beat_src, beat_dst;
  logic [15:0] beat_len;
  logic [3:0]  done_code;

  dma3d_addr_gen uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] cs [64], cd [64];
  logic [15:0] cl [64];
  int cn, ccode;
  bit cdone, cmiss;

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put(input bit lnk, input int slot, input int src, input int dst,
                     input int a, input int b, input int c, input int sb, input int db,
                     input int sc, input int dc, input bit sf, input bit df,
                     input int sy, input int tcc, input int link);
    wr_en = 1; wr_link = lnk; wr_slot = slot[1:0];
    wr_src = src; wr_dst = dst; wr_acnt = a[15:0]; wr_bcnt = b[15:0]; wr_ccnt = c[15:0];
    wr_src_bidx = sb[15:0]; wr_dst_bidx = db[15:0]; wr_src_cidx = sc[15:0]; wr_dst_cidx = dc[15:0];
    wr_src_fifo = sf; wr_dst_fifo = df; wr_sync = sy[1:0]; wr_tcc = tcc[3:0]; wr_link_addr = link[15:0];
    @(negedge clk);
    wr_en = 0; wr_link = 0;
  endtask

  task automatic collect(input bit do_trig, input int lim);
    cn = 0; cdone = 0; cmiss = 0; ccode = 0;
    if (do_trig) begin
      trig = 1; @(negedge clk); trig = 0;
    end
    for (int i = 0; i < lim; i++) begin
      if (done) begin cdone = 1; ccode = done_code; end
      if (miss) cmiss = 1;
      if (beat_valid) begin
        if (cn < 64) begin cs[cn] = beat_src; cd[cn] = beat_dst; cl[cn] = beat_len; end
        cn++;
      end else if (cn > 0) break;
      @(negedge clk);
    end
  endtask

  function automatic longint ea(input int base, input bit fifo, input int b, input int f,
                                input int bi, input int ci);
    return fifo ? longint'(base) : longint'(32'(base + f*ci + b*bi));
  endfunction

  task automatic verify(input string rq, input int n, input int bcnt, input int first, input int len,
                        input int sbase, input bit sf, input int sb, input int sc,
                        input int dbase, input bit df, input int db, input int dc);
    chk({rq, " beat count"}, cn, n);
    for (int k = 0; k < n && k < cn; k++) begin
      chk({rq, " src"}, cs[k], ea(sbase, sf, (first+k)%bcnt, (first+k)/bcnt, sb, sc));
      chk({rq, " dst"}, cd[k], ea(dbase, df, (first+k)%bcnt, (first+k)/bcnt, db, dc));
      chk({rq, " len"}, cl[k], len);
    end
  endtask

  task automatic t_reset;
    chk("R1 valid", beat_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 miss", miss, 0);
    collect(1, 4);
    chk("R1 null trigger beats", cn, 0);
  endtask

  task automatic t_array;
    put(0, 0, 'h1000, 'h2000, 8, 3, 2, 16, 32, 100, -64, 0, 0, 0, 5, 'hFFFF);
    for (int j = 0; j < 6; j++) begin
      collect(1, 4);
      verify("R2 R5 R6", 1, 3, j, 8, 'h1000, 0, 16, 100, 'h2000, 0, 32, -64);
      chk("R9 done only at end", cdone, j == 5);
    end
    chk("R9 done code", ccode, 5);
    collect(1, 5);
    chk("R11 null beats", cn, 0);
    chk("R11 null done", cdone, 0);
    chk("R11 null miss", cmiss, 0);
  endtask

  task automatic t_frame_link;
    put(1, 2, 'h3000, 'h4000, 2, 2, 3, 4, 'h10, 8, 'h100, 1, 0, 2, 9, 2);
    put(0, 0, 'h100, 'h8000, 4, 4, 2, -4, 12, 'h40, 7, 0, 1, 1, 7, 2);
    collect(1, 12);
    verify("R3 R6 R7 frame0", 4, 4, 0, 4, 'h100, 0, -4, 'h40, 'h8000, 1, 12, 7);
    chk("R3 no done mid block", cdone, 0);
    collect(1, 12);
    verify("R5 R7 frame1", 4, 4, 4, 4, 'h100, 0, -4, 'h40, 'h8000, 1, 12, 7);
    chk("R9 frame done", cdone, 1);
    chk("R9 frame code", ccode, 7);
    for (int r = 0; r < 2; r++) begin
      collect(1, 12);
      verify("R4 R10 linked block", 6, 2, 0, 2, 'h3000, 1, 4, 8, 'h4000, 0, 'h10, 'h100);
      chk("R10 linked done", cdone, 1);
      chk("R10 linked code", ccode, 9);
    end
  endtask

  task automatic t_stall_miss;
    logic [31:0] s0, d0;
    put(0, 0, 'h500, 'h900, 6, 3, 1, 8, -8, 0, 0, 0, 0, 1, 3, 'hFFFF);
    beat_ready = 0;
    trig = 1; @(negedge clk); trig = 0;
    chk("R8 valid", beat_valid, 1);
    s0 = beat_src; d0 = beat_dst;
    chk("R8 first src", s0, 'h500);
    repeat (3) @(negedge clk);
    chk("R8 src held", beat_src, s0);
    chk("R8 dst held", beat_dst, d0);
    trig = 1; @(negedge clk); trig = 0;
    chk("R12 miss", miss, 1);
    @(negedge clk);
    chk("R12 miss one cycle", miss, 0);
    beat_ready = 1;
    collect(0, 12);
    verify("R12 burst", 3, 3, 0, 6, 'h500, 0, 8, 0, 'h900, 0, -8, 0);
    chk("R12 done", cdone, 1);
    repeat (4) @(negedge clk);
    chk("R12 not queued", beat_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_array;
    t_frame_link;
    t_stall_miss;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule